// File: doc/BRIEF.md
# Packed Exponent-Acceleration Lookup Unit

This block is a SIMD helper for exponential routines. It splits a packed source vector into 16-, 32- or 64-bit lanes, chosen by a two-bit size code. For each lane it builds a floating-point bit pattern with no arithmetic at all. The sign bit is cleared. A window of input bits is copied straight into the exponent field. The fraction comes from a constant table of 2^(k/N) fractions, indexed by the lowest input bits.

Software uses this to finish a 2^x computation after a range reduction. The reduction leaves the integer part of x above the table index, and the result is the power of two scaled by the table entry. A valid/ready handshake accepts one vector per cycle. The result is held in an output register until the consumer takes it.

Top module: `exa_unit`

## Requirements
- R1: The size code selects the lane width. 2'b01 selects 16-bit lanes, 2'b10 selects 32-bit lanes and 2'b11 selects 64-bit lanes.
- R2: In a 64-bit lane, result bits 62:52 equal input bits 16:6. Result bits 51:0 equal round(2^52·(2^(k/64)−1)), where k is input bits 5:0.
- R3: In a 32-bit lane, result bits 30:23 equal input bits 13:6. Result bits 22:0 equal round(2^23·(2^(k/64)−1)), where k is input bits 5:0.
- R4: In a 16-bit lane, result bits 14:10 equal input bits 9:5. Result bits 9:0 equal round(2^10·(2^(k/32)−1)), where k is input bits 4:0.
- R5: The top bit of every result lane is zero. Input bits above the exponent window have no effect on the result.
- R6: Every lane is processed independently, and its result lands in the same lane position of out_vec. There is no masking.
- R7: Size code 2'b00 is reserved. It sets out_illegal and forces out_vec to all zeros. A legal code clears out_illegal.
- R8: A transfer is accepted at a rising edge where in_valid and in_ready are both high. out_valid and the result appear on that same edge. out_valid falls at the next edge where out_ready is high and no new transfer is accepted.
- R9: While out_valid is high and out_ready is low, in_ready is low, and out_vec and out_illegal hold their values.
- R10: After reset, out_valid, out_illegal and out_vec are zero, and in_ready is high.
- R11: A 32-bit lane holding the single-precision value 131199+j gives exactly 2^j, for −126 ≤ j ≤ 127. Likewise, a 16-bit lane holding 47+j gives 2^j for −14 ≤ j ≤ 15, and a 64-bit lane holding 70368744178687+j gives 2^j for −1022 ≤ j ≤ 1023.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Source vector and size code are valid |
| in_ready | output | 1 | Unit can accept a source vector |
| in_size | input | 2 | Lane size code |
| in_vec | input | VEC_W | Packed source vector |
| out_ready | input | 1 | Consumer takes the result |
| out_valid | output | 1 | Result register holds an untaken result |
| out_illegal | output | 1 | The result came from a reserved size code |
| out_vec | output | VEC_W | Packed result vector |

## Verification
Assertions check the handshake on every cycle. They confirm that ready falls during a stall, that the result and flag hold until taken, that an accepted transfer raises out_valid, and that a reserved code gives a set flag with a zero vector.

Only the bench scenarios can show that the values are right. The bench sweeps every table index for all three lane widths against a reference computed in real arithmetic. It runs the power-of-two identity over the whole exponent range, and it proves that high input bits are ignored and lanes are independent.

// File: rtl/exa_pkg.sv
package exa_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  typedef enum logic [1:0] {
    SZ_RSVD = 2'b00,
    SZ_H    = 2'b01,
    SZ_S    = 2'b10,
    SZ_D    = 2'b11
  } size_e;

  // Fixed-point scale used while building the fraction tables.
  localparam int FX = 128;
  // Each table slot is 64 bits wide and there are at most 64 slots.
  localparam int SLOT = 64;

  function automatic int idx_w(input int lw);
    return (lw == 16) ? 5 : 6;
  endfunction

  function automatic int exp_w(input int lw);
    return (lw == 16) ? 5 : (lw == 32) ? 8 : 11;
  endfunction

  function automatic int frac_w(input int lw);
    return lw - 1 - exp_w(lw);
  endfunction

  // Integer square root, found one result bit at a time.
  function automatic logic [135:0] isqrt(input logic [263:0] n);
    logic [135:0] r;
    logic [135:0] t;
    logic [271:0] sq;
    r = '0;
    for (int b = 135; b >= 0; b--) begin
      t  = r | (136'(1) << b);
      sq = 272'(t) * 272'(t);
      if (sq <= {8'd0, n}) r = t;
    end
    return r;
  endfunction

  // Builds round(2^fw * (2^(k/2^iw) - 1)) for every k.
  // It chains square roots of two in fixed point, with FX fraction bits.
  function automatic logic [SLOT*64-1:0] build_tbl(input int iw, input int fw);
    logic [SLOT*64-1:0] t;
    logic [5:0][263:0]  roots;
    logic [263:0]       rt;
    logic [263:0]       p;
    t  = '0;
    rt = 264'(isqrt(264'(1) << (2 * FX + 1)));  // 2^(1/2)
    for (int i = 0; i < 6; i++) begin
      roots[i] = rt;                            // 2^(1/2^(i+1))
      rt = 264'(isqrt(rt << FX));
    end
    for (int k = 0; k < (1 << iw); k++) begin
      p = 264'(1) << FX;
      for (int i = 0; i < iw; i++)
        if (k[iw-1-i]) p = (p * roots[i]) >> FX;
      p = (p + (264'(1) << (FX - fw - 1))) >> (FX - fw);
      p = p - (264'(1) << fw);
      t[k*SLOT +: SLOT] = p[SLOT-1:0];
    end
    return t;
  endfunction

  localparam logic [SLOT*64-1:0] TBL_H = build_tbl(5, 10);
  localparam logic [SLOT*64-1:0] TBL_S = build_tbl(6, 23);
  localparam logic [SLOT*64-1:0] TBL_D = build_tbl(6, 52);
endpackage

// File: rtl/exa_frac_rom.sv
module exa_frac_rom
  import exa_pkg::*;
#(
  parameter int LANE_W = 32,
  localparam int IW = idx_w(LANE_W),
  localparam int FW = frac_w(LANE_W)
) (
  input  logic [IW-1:0] idx,
  output logic [FW-1:0] frac
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam logic [SLOT*64-1:0] TBL =
    (LANE_W == 16) ? TBL_H : (LANE_W == 32) ? TBL_S : TBL_D;

  always_comb frac = TBL[SLOT*int'(idx) +: FW];
endmodule

// File: rtl/exa_lane.sv
module exa_lane
  import exa_pkg::*;
#(
  parameter int LANE_W = 32,
  localparam int IW = idx_w(LANE_W),
  localparam int EW = exp_w(LANE_W),
  localparam int FW = frac_w(LANE_W)
) (
  input  logic [LANE_W-1:0] x,
  output logic [LANE_W-1:0] y
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [FW-1:0] frac;
  logic [EW-1:0] expo;
  logic          unused_hi;

  exa_frac_rom #(.LANE_W(LANE_W)) i_rom (
    .idx  (x[IW-1:0]),
    .frac (frac)
  );

  // The exponent window sits directly above the table index.
  assign expo      = x[IW +: EW];
  assign unused_hi = ^x[LANE_W-1:IW+EW];
  assign y         = {1'b0, expo, frac};
endmodule

// File: rtl/exa_unit.sv
module exa_unit
  import exa_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [1:0]       in_size,
  input  logic [VEC_W-1:0] in_vec,
  input  logic             out_ready,
  output logic             out_valid,
  output logic             out_illegal,
  output logic [VEC_W-1:0] out_vec
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int NSIZE = 3;

  if (VEC_W % 64 != 0) begin : g_bad_width
    $error("VEC_W must be a multiple of 64");
  end

  logic [NSIZE-1:0][VEC_W-1:0] res;
  logic [VEC_W-1:0]            nxt_vec;
  logic                        size_rsvd;
  logic                        accept;
  logic                        stall;

  for (genvar gs = 0; gs < NSIZE; gs++) begin : g_size
    localparam int LW = 16 << gs;
    for (genvar l = 0; l < VEC_W / LW; l++) begin : g_lane
      exa_lane #(.LANE_W(LW)) i_lane (
        .x (in_vec[l*LW +: LW]),
        .y (res[gs][l*LW +: LW])
      );
    end
  end

  assign size_rsvd = (size_e'(in_size) == SZ_RSVD);
  assign stall     = out_valid && !out_ready;
  assign in_ready  = !stall;
  assign accept    = in_valid && in_ready;

  always_comb begin
    case (size_e'(in_size))
      SZ_H:    nxt_vec = res[0];
      SZ_S:    nxt_vec = res[1];
      SZ_D:    nxt_vec = res[2];
      default: nxt_vec = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_illegal <= 1'b0;
      out_vec     <= '0;
    end else if (accept) begin
      out_valid   <= 1'b1;
      out_illegal <= size_rsvd;
      out_vec     <= nxt_vec;
    end else if (out_ready) begin
      out_valid   <= 1'b0;
    end
  end

  // R9: no transfer is taken while a result waits
  a_r9_ready_low: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);
  // R9: a waiting result holds its value
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> out_valid && $stable(out_vec) && $stable(out_illegal));
  // R8: an accepted transfer shows up on the next cycle
  a_r8_valid: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);
  // R7: a reserved code sets the flag
  a_r7_flag: assert property (@(posedge clk) disable iff (!rst_n)
    accept && size_rsvd |=> out_illegal);
  // R7: a legal code clears the flag
  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !size_rsvd |=> !out_illegal);
  // R7: a flagged result is all zeros
  a_r7_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_illegal |-> out_vec == '0);
endmodule

// File: tb/test_exa_unit.sv
module test_exa_unit;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int VW = 128;
  localparam int NT = 7;

  // Directed table: size code, stimulus, expected result.
  localparam logic [1:0] T_SZ [NT] = '{2'b01, 2'b10, 2'b11, 2'b10, 2'b01, 2'b11, 2'b00};
  localparam logic [VW-1:0] T_IN [NT] = '{
    {8{16'hFFE0}},
    {4{32'hFFFF_FFC0}},
    {2{64'hFFFF_FFFF_FFFF_FFC0}},
    {4{32'h0000_0020}},
    {8{16'h8010}},
    {64'h8000_0000_0000_0060, 64'h0000_0000_0000_0020},
    {VW{1'b1}}
  };
  localparam logic [VW-1:0] T_EXP [NT] = '{
    {8{16'h7C00}},
    {4{32'h7F80_0000}},
    {2{64'h7FF0_0000_0000_0000}},
    {4{32'h0035_04F3}},
    {8{16'h01A8}},
    {64'h0016_A09E_667F_3BCD, 64'h0006_A09E_667F_3BCD},
    {VW{1'b0}}
  };
  localparam string T_TAG [NT] = '{"R4", "R3", "R2", "R5", "R1", "R6", "R7"};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [1:0]    in_size = 2'b00;
  logic [VW-1:0] in_vec = '0;
  logic          out_ready = 1'b1;
  logic          out_valid;
  logic          out_illegal;
  logic [VW-1:0] out_vec;
  int            n_chk = 0;
  int            n_fail = 0;

  always #2 clk = ~clk;

  exa_unit #(.VEC_W(VW)) i_exa_unit (
    .clk, .rst_n, .in_valid, .in_ready, .in_size, .in_vec,
    .out_ready, .out_valid, .out_illegal, .out_vec
  );

  task automatic chk(input string tag, input bit ok,
                     input logic [VW-1:0] got, input logic [VW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic int lw_of(input logic [1:0] sz);
    return 8 << sz;
  endfunction

  // Reference model, written from the requirements.
  function automatic logic [63:0] ref_lane(input int lw, input logic [63:0] x);
    int kb, eb, fb;
    longint k, e, f;
    real r;
    kb = (lw == 16) ? 5 : 6;
    eb = (lw == 16) ? 5 : (lw == 32) ? 8 : 11;
    fb = lw - 1 - eb;
    k  = longint'(x % (64'd1 << kb));
    e  = longint'((x / (64'd1 << kb)) % (64'd1 << eb));
    r  = (2.0 ** (real'(k) / real'(64'd1 << kb)) - 1.0) * (2.0 ** fb);
    f  = longint'($floor(r + 0.5));
    return 64'(e) * (64'd1 << fb) + 64'(f);
  endfunction

  function automatic logic [VW-1:0] ref_vec(input logic [1:0] sz, input logic [VW-1:0] v);
    logic [VW-1:0] o;
    int lw;
    o  = '0;
    lw = lw_of(sz);
    if (sz != 2'b00)
      for (int l = 0; l < VW / lw; l++)
        for (int b = 0; b < lw; b++) o[l*lw+b] = ref_lane(lw, 64'(v >> (l*lw)))[b];
    return o;
  endfunction

  // A double reference cannot resolve the last fraction unit of 64-bit lanes.
  function automatic bit vec_ok(input logic [1:0] sz, input logic [VW-1:0] got,
                                input logic [VW-1:0] exp);
    longint dg, de;
    if (sz != 2'b11) return got == exp;
    for (int l = 0; l < VW / 64; l++) begin
      dg = longint'(got[l*64 +: 64]);
      de = longint'(exp[l*64 +: 64]);
      if (dg - de > 1 || de - dg > 1) return 1'b0;
    end
    return 1'b1;
  endfunction

  function automatic logic [31:0] to_single(input real v);
    logic [63:0] b;
    int e;
    b = $realtobits(v);
    e = int'(b[62:52]) - 1023 + 127;
    return {b[63], e[7:0], b[51:29]};
  endfunction

  function automatic logic [15:0] to_half(input real v);
    logic [63:0] b;
    int e;
    b = $realtobits(v);
    e = int'(b[62:52]) - 1023 + 15;
    return {b[63], e[4:0], b[51:42]};
  endfunction

  // One transfer with out_ready high; the result is sampled after the accepting edge.
  task automatic xfer(input logic [1:0] sz, input logic [VW-1:0] v,
                      output logic [VW-1:0] got, output logic ill);
    in_valid  = 1'b1;
    in_size   = sz;
    in_vec    = v;
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R8", out_valid === 1'b1, VW'(out_valid), VW'(1));
    got      = out_vec;
    ill      = out_illegal;
    in_valid = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [VW-1:0] got, a_exp, b_exp, v;
    logic          ill;

    // R10: reset state
    repeat (3) @(negedge clk);
    chk("R10", out_valid === 1'b0 && out_illegal === 1'b0 && in_ready === 1'b1,
        VW'({out_valid, out_illegal, in_ready}), VW'(3'b001));
    chk("R10", out_vec === '0, out_vec, '0);
    rst_n = 1'b1;
    @(negedge clk);

    // Directed table
    for (int i = 0; i < NT; i++) begin
      xfer(T_SZ[i], T_IN[i], got, ill);
      chk(T_TAG[i], got === T_EXP[i], got, T_EXP[i]);
      chk("R7", ill === (T_SZ[i] == 2'b00), VW'(ill), VW'(T_SZ[i] == 2'b00));
    end

    // R2 R3 R4 R6: every table index, with lanes mixing indices and exponents
    for (int sz = 1; sz < 4; sz++) begin
      int lw, kb, eb, depth;
      lw    = 8 << sz;
      kb    = (lw == 16) ? 5 : 6;
      eb    = (lw == 16) ? 5 : (lw == 32) ? 8 : 11;
      depth = 1 << kb;
      for (int s = 0; s < depth; s++) begin
        v = '0;
        for (int l = 0; l < VW / lw; l++) begin
          logic [63:0] x;
          x = 64'hA5C3_9E71_B24D_6F08 * 64'(s + 3 * l + 1);
          x = (x << (kb + eb)) | (64'((s * 7 + l * 3) % (1 << eb)) << kb)
              | 64'((s + l) % depth);
          for (int b = 0; b < lw; b++) v[l*lw+b] = x[b];
        end
        xfer(2'(sz), v, got, ill);
        a_exp = ref_vec(2'(sz), v);
        chk(sz == 1 ? "R4" : sz == 2 ? "R3" : "R2", vec_ok(2'(sz), got, a_exp), got, a_exp);
      end
    end

    // R11: power-of-two identity, 32-bit lanes
    for (int j = -126; j <= 127; j++) begin
      xfer(2'b10, {4{to_single(131199.0 + j)}}, got, ill);
      a_exp = {4{to_single(2.0 ** j)}};
      chk("R11", got === a_exp, got, a_exp);
    end
    // R11: 16-bit lanes
    for (int j = -14; j <= 15; j++) begin
      xfer(2'b01, {8{to_half(47.0 + j)}}, got, ill);
      a_exp = {8{to_half(2.0 ** j)}};
      chk("R11", got === a_exp, got, a_exp);
    end
    // R11: 64-bit lanes
    for (int j = -1022; j <= 1023; j += 31) begin
      xfer(2'b11, {2{$realtobits(70368744178687.0 + j)}}, got, ill);
      a_exp = {2{$realtobits(2.0 ** j)}};
      chk("R11", got === a_exp, got, a_exp);
    end

    // R8: valid falls once the result is taken with no new transfer
    @(negedge clk);
    chk("R8", out_valid === 1'b0, VW'(out_valid), VW'(0));

    // R9: backpressure
    a_exp = ref_vec(2'b10, {4{32'h0000_1234}});
    b_exp = ref_vec(2'b01, {8{16'h0321}});
    in_valid  = 1'b1;
    in_size   = 2'b10;
    in_vec    = {4{32'h0000_1234}};
    out_ready = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R9", in_ready === 1'b0 && out_valid === 1'b1, VW'({in_ready, out_valid}), VW'(2'b01));
    in_size = 2'b01;
    in_vec  = {8{16'h0321}};
    @(posedge clk);
    @(negedge clk);
    chk("R9", out_vec === a_exp && out_valid === 1'b1, out_vec, a_exp);
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R9", out_vec === b_exp && out_valid === 1'b1, out_vec, b_exp);
    in_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R8", out_valid === 1'b0, VW'(out_valid), VW'(0));

    // R7: a reserved code after a legal result gives zeros; the flag clears again
    xfer(2'b00, {VW{1'b1}}, got, ill);
    chk("R7", got === '0 && ill === 1'b1, got, '0);
    xfer(2'b01, '0, got, ill);
    chk("R7", ill === 1'b0 && got === '0, VW'(ill), VW'(0));

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule